// File: doc/BRIEF.md
# Fault-Only-First Vector Load Sequencer

This block walks the elements of a single fault-only-first vector load, unit-stride or segmented, one memory request at a time. For each element (and each field of a segment) it issues a request, waits for the response status and decides what to do. It can write the returned data to the destination register, raise a precise trap, or shorten the active vector length. The rule it enforces is simple. Element 0 either completes or traps. Any later element may end the instruction early by shortening vl to its index. Debug watchpoints and interrupts never shorten vl.

The surrounding pipeline starts the block with the entry vl, vstart, the number of fields per segment and two policy inputs. One policy input lets a slow cache miss shorten vl. The other chooses whether a pending interrupt is held until the instruction ends or taken between elements. When the instruction ends, the block reports the resulting vl and vstart, and a trap request if one was raised. The response must carry the element's memory address so that a trap can report it.

Top module: `ffload_seq`

## Requirements
- R1: A fault response (status code 1) on element 0, in any field, raises a trap with cause code 1 and vstart 0. The trap reports the address carried by that response, and vl stays at its entry value.
- R2: A fault response on an element with index e > 0 ends the instruction with vl = e, no trap, and that element not written.
- R3: The resulting vl is never 0 unless vl was 0 on entry. A slow-miss response (status code 2) on element 0 is written like a normal completion.
- R4: When the miss-trim input is 1, a slow-miss response on element e > 0 ends the instruction with vl = e and no trap. When the input is 0, the slow-miss data is written and the sequence continues.
- R5: A watchpoint response (status code 3) raises a trap with cause code 2 and vstart equal to that element. The trap reports the response address, and vl stays at its entry value.
- R6: With the interrupt-defer input at 1, a pending interrupt has no effect and the instruction completes normally. With it at 0, the interrupt is taken once the current element has fully completed and elements remain. This raises a trap with cause code 3, vstart equal to the next element and vl unchanged.
- R7: In a segmented load, a fault in any field of segment e > 0 ends the instruction with vl = e. Fields of that segment that came back before the fault may already have been written.
- R8: Processing starts at the entry vstart, and no element below it is requested. A completion without a trap reports vstart 0.
- R9: Write enables occur only with an accepted response and only for elements below the resulting vl. The only exception is the partial segment of R7. Each write carries the response data.
- R10: If vl is 0 on entry, or vstart is at or above vl, the block finishes with no request, no write and no trap. It reports vl unchanged and vstart 0.
- R11: Requests go in element order with fields innermost, one outstanding at a time. A request stalled by a low ready keeps its element and field.
- R12: The done output is a one-cycle pulse. A trap request is a one-cycle pulse in the cycle immediately before done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one instruction (accepted when idle) |
| cfg_vl | input | VL_W | Entry vector length |
| cfg_vstart | input | VL_W | Entry start element |
| cfg_nf_m1 | input | NF_W | Fields per segment minus one (0 = unit-stride) |
| cfg_miss_trim | input | 1 | Allow a slow miss after element 0 to shorten vl |
| cfg_irq_defer | input | 1 | 1: hold interrupts until the end; 0: take between elements |
| irq_pending | input | 1 | Interrupt waiting |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_elem | output | VL_W | Requested element |
| req_field | output | NF_W | Requested field within the segment |
| rsp_valid | input | 1 | Response for the outstanding request |
| rsp_status | input | 2 | 0 ok, 1 fault, 2 slow miss, 3 watchpoint |
| rsp_addr | input | AW | Memory address of the responded element |
| rsp_data | input | DW | Loaded data |
| wr_en | output | 1 | Destination write enable |
| wr_elem | output | VL_W | Element written |
| wr_field | output | NF_W | Field written |
| wr_data | output | DW | Data written |
| done | output | 1 | Instruction finished (one cycle) |
| out_vl | output | VL_W | Resulting vl |
| out_vstart | output | VL_W | Resulting vstart |
| trap_req | output | 1 | Trap raised (one cycle, before done) |
| trap_cause | output | 2 | 0 none, 1 fault, 2 debug, 3 interrupt |
| trap_addr | output | AW | Faulting address (0 for an interrupt) |

## Verification
The hardest case to reach from the ports is a fault in the middle field of a later segment. Here the block must shorten vl to the segment's index while writes for earlier fields of the same segment have already gone out. Another hard case is an interrupt taken exactly at a segment boundary. The scripted memory model injects a chosen status at a chosen (element, field) pair and answers ok everywhere else. Interrupt rows hold the interrupt high from the start, so the first boundary after one completed element is where it must be taken. Alternate rows toggle ready to stall each request.

// File: rtl/ffl_pkg.sv
// Shared types of the fault-only-first load sequencer.
// Assumes: the 2-bit status and cause codes match the port encodings.
package ffl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_TRAP  = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        RS_OK    = 2'd0,
        RS_FAULT = 2'd1,
        RS_MISS  = 2'd2,
        RS_WATCH = 2'd3
    } rsp_status_e;

    typedef enum logic [1:0] {
        CA_NONE  = 2'd0,
        CA_FAULT = 2'd1,
        CA_DEBUG = 2'd2,
        CA_IRQ   = 2'd3
    } trap_cause_e;

    typedef enum logic [1:0] {
        ACT_WRITE    = 2'd0,
        ACT_TRIM     = 2'd1,
        ACT_TRAP_FLT = 2'd2,
        ACT_TRAP_DBG = 2'd3
    } rsp_action_e;

endpackage

// File: rtl/ffl_cursor.sv
// Element/field cursor. Loads a start element with field 0 and steps
// fields innermost, wrapping into the next element after the last field.
// Assumes: nf_m1 is stable while stepping.
module ffl_cursor #(
    parameter int VL_W = 8,
    parameter int NF_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [VL_W-1:0] load_elem,
    input  logic            step,
    input  logic [NF_W-1:0] nf_m1,
    output logic [VL_W-1:0] elem,
    output logic [NF_W-1:0] field,
    output logic            seg_end
);
    localparam logic [VL_W-1:0] ELEM_ONE  = VL_W'(1);
    localparam logic [NF_W-1:0] FIELD_ONE = NF_W'(1);

    // Last field of the current segment.
    assign seg_end = (field == nf_m1);

    // Cursor position register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem  <= '0;
            field <= '0;
        end else if (load) begin
            elem  <= load_elem;
            field <= '0;
        end else if (step) begin
            if (seg_end) begin
                elem  <= elem + ELEM_ONE;
                field <= '0;
            end else begin
                field <= field + FIELD_ONE;
            end
        end
    end
endmodule

// File: rtl/ffl_judge.sv
// Response classifier: maps a status and element index to an action.
// Element 0 never shortens vl; watchpoints never shorten vl.
// Assumes: purely combinational, used only while a response is valid.
module ffl_judge
    import ffl_pkg::*;
#(
    parameter int VL_W = 8
) (
    input  logic [1:0]      status,
    input  logic [VL_W-1:0] elem,
    input  logic            miss_trim,
    output rsp_action_e     action
);
    logic first_elem;
    assign first_elem = (elem == '0);

    // Decide write, trim or trap for one response.
    always_comb begin
        unique case (rsp_status_e'(status))
            RS_OK:    action = ACT_WRITE;
            RS_FAULT: action = first_elem ? ACT_TRAP_FLT : ACT_TRIM;
            RS_MISS:  action = (miss_trim && !first_elem) ? ACT_TRIM : ACT_WRITE;
            RS_WATCH: action = ACT_TRAP_DBG;
            default:  action = ACT_WRITE;
        endcase
    end
endmodule

// File: rtl/ffload_seq.sv
// Fault-only-first vector load sequencer (top).
// Issues one request per element field, one outstanding, and applies the
// trim/trap rules to each response. Results are held until next start.
// Assumes: a response arrives only for the outstanding request; start is
// only honoured in the idle state.
module ffload_seq
    import ffl_pkg::*;
#(
    parameter int VL_W = 8,
    parameter int NF_W = 3,
    parameter int AW   = 32,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VL_W-1:0] cfg_vl,
    input  logic [VL_W-1:0] cfg_vstart,
    input  logic [NF_W-1:0] cfg_nf_m1,
    input  logic            cfg_miss_trim,
    input  logic            cfg_irq_defer,
    input  logic            irq_pending,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [VL_W-1:0] req_elem,
    output logic [NF_W-1:0] req_field,
    input  logic            rsp_valid,
    input  logic [1:0]      rsp_status,
    input  logic [AW-1:0]   rsp_addr,
    input  logic [DW-1:0]   rsp_data,
    output logic            wr_en,
    output logic [VL_W-1:0] wr_elem,
    output logic [NF_W-1:0] wr_field,
    output logic [DW-1:0]   wr_data,
    output logic            done,
    output logic [VL_W-1:0] out_vl,
    output logic [VL_W-1:0] out_vstart,
    output logic            trap_req,
    output logic [1:0]      trap_cause,
    output logic [AW-1:0]   trap_addr
);
    localparam logic [VL_W-1:0] ONE = VL_W'(1);

    seq_state_e      state_q, state_d;
    logic [VL_W-1:0] vl_q;
    logic [NF_W-1:0] nf_q;
    logic            miss_q;
    logic            defer_q;
    logic [VL_W-1:0] elem;
    logic [NF_W-1:0] field;
    logic            seg_end;
    logic            last_elem;
    logic            empty_entry;
    logic            take_rsp;
    logic            irq_take;
    logic            cur_load;
    logic            cur_step;
    rsp_action_e     action;

    assign empty_entry = (cfg_vl == '0) || (cfg_vstart >= cfg_vl);
    assign last_elem   = (elem == vl_q - ONE);
    assign take_rsp    = (state_q == ST_WAIT) && rsp_valid;
    assign irq_take    = irq_pending && !defer_q && seg_end && !last_elem;
    assign cur_load    = (state_q == ST_IDLE) && start;
    assign cur_step    = take_rsp && (action == ACT_WRITE);

    ffl_cursor #(.VL_W(VL_W), .NF_W(NF_W)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cur_load),
        .load_elem (cfg_vstart),
        .step      (cur_step),
        .nf_m1     (nf_q),
        .elem      (elem),
        .field     (field),
        .seg_end   (seg_end)
    );

    ffl_judge #(.VL_W(VL_W)) u_judge (
        .status    (rsp_status),
        .elem      (elem),
        .miss_trim (miss_q),
        .action    (action)
    );

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = empty_entry ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (req_ready) state_d = ST_WAIT;
            ST_WAIT: begin
                if (rsp_valid) begin
                    unique case (action)
                        ACT_WRITE: begin
                            if (seg_end && last_elem) state_d = ST_DONE;
                            else if (irq_take)        state_d = ST_TRAP;
                            else                      state_d = ST_ISSUE;
                        end
                        ACT_TRIM:     state_d = ST_DONE;
                        ACT_TRAP_FLT: state_d = ST_TRAP;
                        ACT_TRAP_DBG: state_d = ST_TRAP;
                        default:      state_d = ST_DONE;
                    endcase
                end
            end
            ST_TRAP:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Per-instruction configuration latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q    <= '0;
            nf_q    <= '0;
            miss_q  <= 1'b0;
            defer_q <= 1'b0;
        end else if (cur_load) begin
            vl_q    <= cfg_vl;
            nf_q    <= cfg_nf_m1;
            miss_q  <= cfg_miss_trim;
            defer_q <= cfg_irq_defer;
        end
    end

    // Result registers: vl, vstart, cause and address, held until next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vl     <= '0;
            out_vstart <= '0;
            trap_cause <= CA_NONE;
            trap_addr  <= '0;
        end else if (cur_load) begin
            out_vl     <= cfg_vl;
            out_vstart <= '0;
            trap_cause <= CA_NONE;
            trap_addr  <= '0;
        end else if (take_rsp) begin
            unique case (action)
                ACT_WRITE: begin
                    if (seg_end && !last_elem && irq_take) begin
                        trap_cause <= CA_IRQ;
                        out_vstart <= elem + ONE;
                    end
                end
                ACT_TRIM: out_vl <= elem;
                ACT_TRAP_FLT: begin
                    trap_cause <= CA_FAULT;
                    out_vstart <= elem;
                    trap_addr  <= rsp_addr;
                end
                ACT_TRAP_DBG: begin
                    trap_cause <= CA_DEBUG;
                    out_vstart <= elem;
                    trap_addr  <= rsp_addr;
                end
                default: out_vl <= out_vl;
            endcase
        end
    end

    // Port decode of the request, write and status pulses.
    assign req_valid = (state_q == ST_ISSUE);
    assign req_elem  = elem;
    assign req_field = field;
    assign wr_en     = cur_step;
    assign wr_elem   = elem;
    assign wr_field  = field;
    assign wr_data   = rsp_data;
    assign done      = (state_q == ST_DONE);
    assign trap_req  = (state_q == ST_TRAP);
endmodule

// File: rtl/ffl_checker.sv
// Protocol and rule checker for ffload_seq, attached by bind.
// Tracks the entry vl from the start handshake seen at the ports.
module ffl_checker #(
    parameter int VL_W = 8,
    parameter int NF_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [VL_W-1:0] cfg_vl,
    input logic [VL_W-1:0] cfg_vstart,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VL_W-1:0] req_elem,
    input logic [NF_W-1:0] req_field,
    input logic            rsp_valid,
    input logic            wr_en,
    input logic            done,
    input logic            trap_req,
    input logic [VL_W-1:0] out_vl
);
    logic            busy_q;
    logic            empty_q;
    logic [VL_W-1:0] ent_vl;

    // Track the instruction in flight as seen from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            empty_q <= 1'b0;
            ent_vl  <= '0;
        end else if (start && !busy_q) begin
            busy_q  <= 1'b1;
            ent_vl  <= cfg_vl;
            empty_q <= (cfg_vl == '0) || (cfg_vstart >= cfg_vl);
        end else if (done) begin
            busy_q  <= 1'b0;
            empty_q <= 1'b0;
        end
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_elem) && $stable(req_field));
    p_trap_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> done);
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_vl_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_vl != '0) || (ent_vl == '0));
    p_trap_keeps_vl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> out_vl == ent_vl);
    p_empty_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        empty_q |-> !req_valid && !wr_en && !trap_req);
    p_wr_needs_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rsp_valid);
    p_elem_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_elem < ent_vl);
endmodule

bind ffload_seq ffl_checker #(.VL_W(VL_W), .NF_W(NF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_vl     (cfg_vl),
    .cfg_vstart (cfg_vstart),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_elem   (req_elem),
    .req_field  (req_field),
    .rsp_valid  (rsp_valid),
    .wr_en      (wr_en),
    .done       (done),
    .trap_req   (trap_req),
    .out_vl     (out_vl)
);

// File: tb/sim_ffload_seq.sv
// Bench for ffload_seq: table of scenarios with a scripted memory, then
// directed reset checks.
module sim_ffload_seq;
    localparam int VL_W = 8;
    localparam int NF_W = 3;
    localparam int AW   = 32;
    localparam int DW   = 32;

    typedef struct packed {
        logic [7:0] vl;
        logic [7:0] vs;
        logic [2:0] nfm1;
        logic       miss;
        logic       defer;
        logic       irq;
        logic [7:0] ev_e;
        logic [2:0] ev_f;
        logic [1:0] ev_st;
        logic [7:0] x_vl;
        logic [7:0] x_vs;
        logic [1:0] x_cause;
        logic [7:0] x_wr;
    } row_t;

    localparam int NROWS = 18;
    localparam row_t ROWS [NROWS] = '{
        '{8'd5, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'd255, 3'd0, 2'd0, 8'd5, 8'd0, 2'd0, 8'd5},
        '{8'd4, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'd0,   3'd0, 2'd1, 8'd4, 8'd0, 2'd1, 8'd0},
        '{8'd6, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'd3,   3'd0, 2'd1, 8'd3, 8'd0, 2'd0, 8'd3},
        '{8'd6, 8'd0, 3'd0, 1'b1, 1'b0, 1'b0, 8'd2,   3'd0, 2'd2, 8'd2, 8'd0, 2'd0, 8'd2},
        '{8'd6, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'd2,   3'd0, 2'd2, 8'd6, 8'd0, 2'd0, 8'd6},
        '{8'd3, 8'd0, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0,   3'd0, 2'd2, 8'd3, 8'd0, 2'd0, 8'd3},
        '{8'd5, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'd2,   3'd0, 2'd3, 8'd5, 8'd2, 2'd2, 8'd2},
        '{8'd4, 8'd0, 3'd2, 1'b0, 1'b0, 1'b0, 8'd2,   3'd1, 2'd1, 8'd2, 8'd0, 2'd0, 8'd7},
        '{8'd4, 8'd0, 3'd2, 1'b0, 1'b0, 1'b0, 8'd0,   3'd2, 2'd1, 8'd4, 8'd0, 2'd1, 8'd2},
        '{8'd5, 8'd2, 3'd0, 1'b0, 1'b0, 1'b0, 8'd255, 3'd0, 2'd0, 8'd5, 8'd0, 2'd0, 8'd3},
        '{8'd4, 8'd0, 3'd0, 1'b0, 1'b1, 1'b1, 8'd255, 3'd0, 2'd0, 8'd4, 8'd0, 2'd0, 8'd4},
        '{8'd4, 8'd1, 3'd0, 1'b0, 1'b0, 1'b1, 8'd255, 3'd0, 2'd0, 8'd4, 8'd2, 2'd3, 8'd1},
        '{8'd0, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'd255, 3'd0, 2'd0, 8'd0, 8'd0, 2'd0, 8'd0},
        '{8'd3, 8'd3, 3'd0, 1'b0, 1'b0, 1'b0, 8'd255, 3'd0, 2'd0, 8'd3, 8'd0, 2'd0, 8'd0},
        '{8'd5, 8'd2, 3'd0, 1'b0, 1'b0, 1'b0, 8'd2,   3'd0, 2'd1, 8'd2, 8'd0, 2'd0, 8'd0},
        '{8'd3, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'd0,   3'd0, 2'd3, 8'd3, 8'd0, 2'd2, 8'd0},
        '{8'd3, 8'd0, 3'd1, 1'b0, 1'b0, 1'b0, 8'd1,   3'd1, 2'd3, 8'd3, 8'd1, 2'd2, 8'd3},
        '{8'd2, 8'd0, 3'd0, 1'b0, 1'b0, 1'b1, 8'd255, 3'd0, 2'd0, 8'd2, 8'd1, 2'd3, 8'd1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [VL_W-1:0] cfg_vl = '0;
    logic [VL_W-1:0] cfg_vstart = '0;
    logic [NF_W-1:0] cfg_nf_m1 = '0;
    logic            cfg_miss_trim = 1'b0;
    logic            cfg_irq_defer = 1'b0;
    logic            irq_pending = 1'b0;
    logic            req_valid;
    logic            req_ready = 1'b1;
    logic [VL_W-1:0] req_elem;
    logic [NF_W-1:0] req_field;
    logic            rsp_valid = 1'b0;
    logic [1:0]      rsp_status = '0;
    logic [AW-1:0]   rsp_addr = '0;
    logic [DW-1:0]   rsp_data = '0;
    logic            wr_en;
    logic [VL_W-1:0] wr_elem;
    logic [NF_W-1:0] wr_field;
    logic [DW-1:0]   wr_data;
    logic            done;
    logic [VL_W-1:0] out_vl;
    logic [VL_W-1:0] out_vstart;
    logic            trap_req;
    logic [1:0]      trap_cause;
    logic [AW-1:0]   trap_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    ffload_seq #(.VL_W(VL_W), .NF_W(NF_W), .AW(AW), .DW(DW)) u0 (.*);

    function automatic logic [AW-1:0] addr_of(input int e, input int f, input int nf);
        return AW'(32'h1000 + 4 * (e * nf + f));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Run one table row against a scripted memory.
    task automatic run_row(input row_t r, input bit stall, input int idx);
        int  nf = int'(r.nfm1) + 1;
        int  ee = int'(r.vs);
        int  ef = 0;
        int  nreq = 0, nwr = 0, bad_order = 0, bad_wr = 0;
        int  got_vl = -1, got_vs = -1, got_cause = 0;
        logic [AW-1:0] got_addr = '0;
        bit  pend = 1'b0, fin = 1'b0;
        int  pe = 0, pf = 0;
        @(negedge clk);
        cfg_vl = r.vl; cfg_vstart = r.vs; cfg_nf_m1 = r.nfm1;
        cfg_miss_trim = r.miss; cfg_irq_defer = r.defer; irq_pending = r.irq;
        start = 1'b1;
        for (int cyc = 0; cyc < 500 && !fin; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            rsp_valid = pend;
            if (pend) begin
                rsp_addr   = addr_of(pe, pf, nf);
                rsp_data   = ~addr_of(pe, pf, nf);
                rsp_status = (pe == int'(r.ev_e) && pf == int'(r.ev_f)) ? r.ev_st : 2'd0;
            end
            pend = 1'b0;
            req_ready = stall ? cyc[0] : 1'b1;
            #1;
            if (wr_en) begin
                nwr++;
                if (wr_data != ~addr_of(int'(wr_elem), int'(wr_field), nf)) bad_wr++;
                if (int'(wr_elem) < int'(r.vs)) bad_wr++;
                if (!(wr_elem < r.x_vl || (r.nfm1 != '0 && wr_elem == r.ev_e))) bad_wr++;
            end
            if (trap_req) begin
                got_cause = int'(trap_cause);
                got_addr  = trap_addr;
            end
            if (done) begin
                got_vl = int'(out_vl);
                got_vs = int'(out_vstart);
                fin = 1'b1;
            end else if (req_valid && req_ready) begin
                nreq++;
                if (int'(req_elem) != ee || int'(req_field) != ef) bad_order++;
                pend = 1'b1; pe = int'(req_elem); pf = int'(req_field);
                ef++;
                if (ef == nf) begin ef = 0; ee++; end
            end
        end
        rsp_valid = 1'b0; irq_pending = 1'b0; req_ready = 1'b1;
        if (!fin) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog row %0d: actual 0 expected 1", idx);
        end
        // R2 R4 R7 R3: resulting vl
        check(got_vl == int'(r.x_vl), $sformatf("R2/R4/R7 vl row %0d", idx), got_vl, int'(r.x_vl));
        // R8 R5 R6: resulting vstart
        check(got_vs == int'(r.x_vs), $sformatf("R8/R5/R6 vstart row %0d", idx), got_vs, int'(r.x_vs));
        // R1 R5 R6: trap cause (0 when none)
        check(got_cause == int'(r.x_cause), $sformatf("R1/R5/R6 cause row %0d", idx), got_cause, int'(r.x_cause));
        // R9 R7: number of writes and their legality
        check(nwr == int'(r.x_wr), $sformatf("R9 writes row %0d", idx), nwr, int'(r.x_wr));
        check(bad_wr == 0, $sformatf("R9 write legality row %0d", idx), bad_wr, 0);
        // R11: request order; R10: no request when nothing to do
        check(bad_order == 0, $sformatf("R11 order row %0d", idx), bad_order, 0);
        if (r.vl == '0 || r.vs >= r.vl)
            check(nreq == 0, $sformatf("R10 requests row %0d", idx), nreq, 0);
        if (r.x_cause == 2'd1 || r.x_cause == 2'd2)
            check(got_addr == addr_of(int'(r.ev_e), int'(r.ev_f), nf),
                  $sformatf("R1/R5 addr row %0d", idx), int'(got_addr),
                  int'(addr_of(int'(r.ev_e), int'(r.ev_f), nf)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // Reset state (R12: no stray pulses)
        check(!done && !trap_req, "R12 reset pulses", int'(done) + int'(trap_req), 0);
        check(!req_valid && !wr_en, "R11 reset request", int'(req_valid) + int'(wr_en), 0);
        check(out_vl == '0 && trap_cause == 2'd0, "R10 reset results", int'(out_vl), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NROWS; i++) run_row(ROWS[i], i[0], i);
        // Reset in mid-instruction returns to idle (R12)
        @(negedge clk);
        cfg_vl = 8'd6; cfg_vstart = '0; cfg_nf_m1 = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check(!req_valid && !done && !wr_en, "R12 mid reset idle", int'(req_valid), 0);
        rst_n = 1'b1;
        // After mid reset a fresh row still works (R2)
        run_row(ROWS[2], 1'b0, 99);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule